// File: doc/BRIEF.md
# Streaming JSON Syntax Checker

This block validates the syntax of JSON text as it streams past, one byte per clock, without ever backtracking. Each accepted byte is sorted into a character class by combinational logic. A context state machine then decides, in the same cycle, whether that class is legal where the parser stands. The parser may be inside a key, waiting for a colon, inside a string or number value, waiting for a value, or waiting for a separator. A bounded stack records whether each open level is an object or an array, so every closing bracket can be matched against its opener.

The block reports two things. The first is an error flag with a three-bit code, raised combinationally on the cycle the offending byte is presented. The flag then stays latched until reset or a start-of-document strobe. The second is a one-cycle completion pulse on the byte that closes the outermost container. The input is always ready, so the block never back-pressures its source. Documents can follow one another back to back without a strobe between them.

Accepted values are objects, arrays, strings and numbers. A document's top level must be an object or an array. Number spelling is checked loosely: a number begins with a digit or minus sign and continues with digits or the characters `.` `e` `E` `+` `-`.

Top module: `json_syntax_checker`

## Requirements
- R1: `in_ready` is 1 in every cycle. A byte is consumed only in a cycle where `in_valid` is 1, and a cycle with `in_valid` low changes neither the outputs nor the parser's state.
- R2: Whitespace (space 0x20, tab 0x09, LF 0x0A, CR 0x0D) is skipped between tokens. Outside a container, only `{` or `[` may begin a document, so a bare word such as `x` is an unexpected-character error.
- R3: A byte whose class is illegal in the current context raises `err_flag` in that same cycle, with `err_code` = 1 (unexpected). An example is a comma directly after `{`.
- R4: Inside a string, every byte except quote and backslash is ignored, including structural characters. A backslash makes the following byte be skipped, so `\"` does not end the string.
- R5: A number begins with a digit or `-`, continues with digits or `. e E + -`, and ends at whitespace, a comma or a closing bracket. Two numbers separated only by whitespace are an error (code 1).
- R6: An object member is a quoted key, a colon and a value, and members are separated by commas. A value that follows a key without a colon is an error (code 1).
- R7: A closing `}` or `]` whose kind differs from the innermost open container raises code 2 (mismatch).
- R8: An opening bracket that would exceed DEPTH open levels raises code 3 (overflow). Exactly DEPTH levels are accepted.
- R9: A closing bracket when no container is open raises code 4 (underflow).
- R10: Once raised, `err_flag` and `err_code` hold their values, and later bytes are ignored, until `rst` or `sof`.
- R11: `doc_done` pulses for one cycle, together with the closing byte that empties the stack. The next byte may start a new document.
- R12: `sof` clears the error, the stack and the context at the clock edge. A byte presented in the same cycle as `sof` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-document strobe; clears all state |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Always 1 |
| err_flag | output | 1 | Syntax error, same cycle as the offending byte, then sticky |
| err_code | output | 3 | 0 none, 1 unexpected, 2 mismatch, 3 overflow, 4 underflow |
| doc_done | output | 1 | Outermost container closed this cycle |

## Verification
The hardest condition to reach from the ports is a valid document that nests to exactly the maximum depth and also carries strings full of brackets, commas and escaped quotes. Random text almost never forms such a document. The bench therefore builds documents with a generator that keeps its own container stack, so every document it emits is well formed by construction. The generator draws nesting, empty containers, escapes and numbers from a seeded random source, and it runs with a small depth so that the limit is hit often. Directed strings then cover each error code at a known byte position, and the bench checks that each error stays latched.

// File: rtl/json_chk_pkg.sv
package json_chk_pkg;

  typedef enum logic [3:0] {
    CC_WS, CC_DIGIT, CC_MINUS, CC_NUMX, CC_QUOTE, CC_COLON, CC_COMMA,
    CC_LBRACE, CC_RBRACE, CC_LBRACK, CC_RBRACK, CC_BSLASH, CC_OTHER
  } cclass_t;

  typedef enum logic [2:0] {
    EC_NONE       = 3'd0,
    EC_UNEXPECTED = 3'd1,
    EC_MISMATCH   = 3'd2,
    EC_OVERFLOW   = 3'd3,
    EC_UNDERFLOW  = 3'd4
  } ecode_t;

  typedef enum logic [3:0] {
    ST_TOP, ST_OBJ_FIRST, ST_OBJ_KEY, ST_KEY, ST_KEY_ESC, ST_COLON,
    ST_VALUE, ST_ARR_FIRST, ST_STR, ST_STR_ESC, ST_NUM, ST_AFTER, ST_ERR
  } ctx_t;

  localparam logic KIND_OBJ = 1'b0;
  localparam logic KIND_ARR = 1'b1;

  function automatic cclass_t classify(input logic [7:0] b);
    case (b)
      8'h20, 8'h09, 8'h0a, 8'h0d:       return CC_WS;
      8'h2d:                            return CC_MINUS;
      8'h2b, 8'h2e, 8'h65, 8'h45:       return CC_NUMX;
      8'h22:                            return CC_QUOTE;
      8'h3a:                            return CC_COLON;
      8'h2c:                            return CC_COMMA;
      8'h7b:                            return CC_LBRACE;
      8'h7d:                            return CC_RBRACE;
      8'h5b:                            return CC_LBRACK;
      8'h5d:                            return CC_RBRACK;
      8'h5c:                            return CC_BSLASH;
      default: return (b >= 8'h30 && b <= 8'h39) ? CC_DIGIT : CC_OTHER;
    endcase
  endfunction

  function automatic logic is_open(input cclass_t c);
    return (c == CC_LBRACE) || (c == CC_LBRACK);
  endfunction

  function automatic logic is_close(input cclass_t c);
    return (c == CC_RBRACE) || (c == CC_RBRACK);
  endfunction

  // container kind named by an opening or closing character
  function automatic logic bracket_kind(input cclass_t c);
    return (c == CC_LBRACK) || (c == CC_RBRACK);
  endfunction

  function automatic logic starts_number(input cclass_t c);
    return (c == CC_DIGIT) || (c == CC_MINUS);
  endfunction

  function automatic logic continues_number(input cclass_t c);
    return (c == CC_DIGIT) || (c == CC_MINUS) || (c == CC_NUMX);
  endfunction

endpackage

// File: rtl/json_char_classifier.sv
module json_char_classifier
  import json_chk_pkg::*;
(
  input  logic [7:0] byte_in,
  output cclass_t    cls
);
  assign cls = classify(byte_in);
endmodule

// File: rtl/json_nest_stack.sv
module json_nest_stack #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         push_kind,
  output logic                         top_kind,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         full,
  output logic                         empty
);
  localparam int DW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] kinds;
  logic [DW-1:0]    depth_q;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst || clr)
          kinds[gi] <= 1'b0;
        else if (push && depth_q == DW'(gi))
          kinds[gi] <= push_kind;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)
      depth_q <= '0;
    else if (push && !full)
      depth_q <= depth_q + DW'(1);
    else if (pop && !empty)
      depth_q <= depth_q - DW'(1);
  end

  always_comb begin
    top_kind = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (depth_q == DW'(i + 1)) top_kind = kinds[i];
  end

  assign depth = depth_q;
  assign full  = (depth_q == DW'(DEPTH));
  assign empty = (depth_q == '0);
endmodule

// File: rtl/json_ctx_fsm.sv
module json_ctx_fsm
  import json_chk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sof,
  input  logic                        in_valid,
  input  cclass_t                     cls,
  input  logic                        top_kind,
  input  logic [$clog2(DEPTH+1)-1:0]  depth,
  input  logic                        full,
  input  logic                        empty,
  output logic                        push,
  output logic                        pop,
  output logic                        push_kind,
  output logic                        err_flag,
  output ecode_t                      err_code,
  output logic                        done
);
  localparam int DW = $clog2(DEPTH + 1);

  ctx_t   st, nxt;
  logic   err_q;
  ecode_t code_q;
  logic   bad;
  ecode_t bad_code;
  logic   want_open, want_close, illegal;

  always_comb begin
    nxt        = st;
    want_open  = 1'b0;
    want_close = 1'b0;
    illegal    = 1'b0;
    if (in_valid && !sof && !rst) begin
      case (st)
        ST_TOP: begin
          if (is_open(cls)) want_open = 1'b1;
          else if (is_close(cls)) want_close = 1'b1;
          else if (cls != CC_WS) illegal = 1'b1;
        end
        ST_OBJ_FIRST: begin
          if (cls == CC_QUOTE) nxt = ST_KEY;
          else if (is_close(cls)) want_close = 1'b1;
          else if (cls != CC_WS) illegal = 1'b1;
        end
        ST_OBJ_KEY: begin
          if (cls == CC_QUOTE) nxt = ST_KEY;
          else if (cls != CC_WS) illegal = 1'b1;
        end
        ST_KEY: begin
          if (cls == CC_BSLASH) nxt = ST_KEY_ESC;
          else if (cls == CC_QUOTE) nxt = ST_COLON;
        end
        ST_KEY_ESC: nxt = ST_KEY;
        ST_COLON: begin
          if (cls == CC_COLON) nxt = ST_VALUE;
          else if (cls != CC_WS) illegal = 1'b1;
        end
        ST_VALUE, ST_ARR_FIRST: begin
          if (cls == CC_QUOTE) nxt = ST_STR;
          else if (starts_number(cls)) nxt = ST_NUM;
          else if (is_open(cls)) want_open = 1'b1;
          else if (is_close(cls) && st == ST_ARR_FIRST) want_close = 1'b1;
          else if (cls != CC_WS) illegal = 1'b1;
        end
        ST_STR: begin
          if (cls == CC_BSLASH) nxt = ST_STR_ESC;
          else if (cls == CC_QUOTE) nxt = ST_AFTER;
        end
        ST_STR_ESC: nxt = ST_STR;
        ST_NUM, ST_AFTER: begin
          if (st == ST_NUM && continues_number(cls)) nxt = ST_NUM;
          else if (cls == CC_WS) nxt = ST_AFTER;
          else if (cls == CC_COMMA) nxt = (top_kind == KIND_OBJ) ? ST_OBJ_KEY : ST_VALUE;
          else if (is_close(cls)) want_close = 1'b1;
          else illegal = 1'b1;
        end
        default: nxt = st;
      endcase
    end
  end

  always_comb begin
    push      = 1'b0;
    pop       = 1'b0;
    push_kind = bracket_kind(cls);
    bad       = 1'b0;
    bad_code  = EC_NONE;
    done      = 1'b0;
    if (illegal) begin
      bad = 1'b1; bad_code = EC_UNEXPECTED;
    end else if (want_open) begin
      if (full) begin
        bad = 1'b1; bad_code = EC_OVERFLOW;
      end else begin
        push = 1'b1;
      end
    end else if (want_close) begin
      if (empty) begin
        bad = 1'b1; bad_code = EC_UNDERFLOW;
      end else if (top_kind != bracket_kind(cls)) begin
        bad = 1'b1; bad_code = EC_MISMATCH;
      end else begin
        pop  = 1'b1;
        done = (depth == DW'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sof) begin
      st     <= ST_TOP;
      err_q  <= 1'b0;
      code_q <= EC_NONE;
    end else if (bad) begin
      st     <= ST_ERR;
      err_q  <= 1'b1;
      code_q <= bad_code;
    end else if (push) begin
      st <= (cls == CC_LBRACE) ? ST_OBJ_FIRST : ST_ARR_FIRST;
    end else if (pop) begin
      st <= done ? ST_TOP : ST_AFTER;
    end else begin
      st <= nxt;
    end
  end

  assign err_flag = err_q | bad;
  assign err_code = err_q ? code_q : bad_code;
endmodule

// File: rtl/json_syntax_checker.sv
module json_syntax_checker
  import json_chk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sof,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       err_flag,
  output logic [2:0] err_code,
  output logic       doc_done
);
  localparam int DW = $clog2(DEPTH + 1);

  cclass_t       cls;
  logic          push_ev, pop_ev, push_kind, top_kind, stk_full, stk_empty;
  logic [DW-1:0] stk_depth;
  ecode_t        code_e;

  json_char_classifier u_cls (
    .byte_in (in_data),
    .cls     (cls)
  );

  json_nest_stack #(.DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .clr       (sof),
    .push      (push_ev),
    .pop       (pop_ev),
    .push_kind (push_kind),
    .top_kind  (top_kind),
    .depth     (stk_depth),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  json_ctx_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sof       (sof),
    .in_valid  (in_valid),
    .cls       (cls),
    .top_kind  (top_kind),
    .depth     (stk_depth),
    .full      (stk_full),
    .empty     (stk_empty),
    .push      (push_ev),
    .pop       (pop_ev),
    .push_kind (push_kind),
    .err_flag  (err_flag),
    .err_code  (code_e),
    .done      (doc_done)
  );

  assign err_code = code_e;
  assign in_ready = 1'b1;
endmodule

// File: rtl/json_syntax_checker_sva.sv
module json_syntax_checker_sva #(
  parameter int DEPTH = 16,
  parameter int DW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          sof,
  input logic          in_ready,
  input logic          err_flag,
  input logic [2:0]    err_code,
  input logic          doc_done,
  input logic          push_ev,
  input logic          pop_ev,
  input logic [DW-1:0] stk_depth
);
  a_r1_ready_high: assert property (@(posedge clk) disable iff (rst) in_ready);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sof) && $past(err_flag)) |-> err_flag);

  a_r10_code_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sof) && $past(err_flag)) |-> err_code == $past(err_code));

  a_r11_done_on_last_pop: assert property (@(posedge clk) disable iff (rst)
    doc_done |-> (pop_ev && stk_depth == DW'(1)));

  a_r11_done_then_empty: assert property (@(posedge clk) disable iff (rst)
    doc_done |=> stk_depth == '0);

  a_r3_done_without_error: assert property (@(posedge clk) disable iff (rst)
    doc_done |-> !err_flag);

  a_r8_push_has_room: assert property (@(posedge clk) disable iff (rst)
    push_ev |-> stk_depth < DW'(DEPTH));

  a_r9_pop_not_empty: assert property (@(posedge clk) disable iff (rst)
    pop_ev |-> stk_depth != '0);

  a_r12_sof_empties: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sof)) |-> stk_depth == '0);
endmodule

bind json_syntax_checker json_syntax_checker_sva #(.DEPTH(DEPTH), .DW(DW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .sof       (sof),
  .in_ready  (in_ready),
  .err_flag  (err_flag),
  .err_code  (err_code),
  .doc_done  (doc_done),
  .push_ev   (push_ev),
  .pop_ev    (pop_ev),
  .stk_depth (stk_depth)
);

// File: tb/json_syntax_checker_bench.sv
module json_syntax_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, err_flag, doc_done;
  logic [2:0] err_code;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  json_syntax_checker #(.DEPTH(DEPTH)) u_json_syntax_checker (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .err_flag(err_flag), .err_code(err_code), .doc_done(doc_done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 1'b0; sof = 1'b0;
  endtask

  task automatic do_sof();
    @(negedge clk); in_valid = 1'b0; sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  // drive one byte, sample the same-cycle outputs before the edge
  task automatic feed(input logic [7:0] b, output logic e, output logic [2:0] c, output logic d);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    #1; e = err_flag; c = err_code; d = doc_done;
  endtask

  task automatic run_q(input string req, input int exp_err, input int exp_code,
                       input int exp_dones, input int exp_last);
    int first_err = -1, seen_code = 0, dones = 0, last_done = -1;
    bit sticky_ok = 1'b1;
    logic e, dn; logic [2:0] c;
    for (int i = 0; i < q.size(); i++) begin
      feed(q[i], e, c, dn);
      if (first_err >= 0 && (!e || int'(c) != seen_code)) sticky_ok = 1'b0;
      if (e && first_err < 0) begin first_err = i; seen_code = int'(c); end
      if (dn) begin dones++; last_done = i; end
    end
    idle();
    check(first_err == exp_err, req, "error position", first_err, exp_err);
    check(seen_code == exp_code, req, "error code", seen_code, exp_code);
    check(dones == exp_dones, req, "done pulses", dones, exp_dones);
    if (exp_last >= 0) check(last_done == exp_last, req, "done position", last_done, exp_last);
    if (first_err >= 0) check(sticky_ok, "R10", "error held", int'(sticky_ok), 1);
  endtask

  task automatic run_str(input string s, input string req, input int exp_err,
                         input int exp_code, input int exp_dones, input int exp_last);
    q.delete();
    for (int i = 0; i < s.len(); i++) q.push_back(s[i]);
    do_sof();
    run_q(req, exp_err, exp_code, exp_dones, exp_last);
  endtask

  task automatic emit_ws();
    case ($urandom % 6)
      0: q.push_back(8'h20);
      1: q.push_back(8'h0a);
      2: q.push_back(8'h09);
      default: ;
    endcase
  endtask

  task automatic emit_str();
    int n = $urandom % 5;
    q.push_back(8'h22);
    for (int i = 0; i < n; i++) begin
      case ($urandom % 8)
        0: q.push_back(8'h7b);
        1: q.push_back(8'h5d);
        2: q.push_back(8'h2c);
        3: q.push_back(8'h3a);
        4: begin q.push_back(8'h5c); q.push_back(8'h22); end
        5: begin q.push_back(8'h5c); q.push_back(8'h5c); end
        default: q.push_back(8'h61 + 8'($urandom % 26));
      endcase
    end
    q.push_back(8'h22);
  endtask

  task automatic emit_num();
    if ($urandom % 2) q.push_back(8'h2d);
    q.push_back(8'h30 + 8'($urandom % 10));
    if ($urandom % 2) begin q.push_back(8'h2e); q.push_back(8'h30 + 8'($urandom % 10)); end
    if ($urandom % 3 == 0) begin q.push_back(8'h65); q.push_back(8'h2b); q.push_back(8'h31); end
  endtask

  // builds a well-formed document of nesting at most maxd; appends to q
  task automatic gen_doc(input int maxd);
    bit kinds[$];
    int mode = 0;           // 0 first member, 1 after value, 2 after comma
    int steps = 0;
    emit_ws();
    kinds.push_back(1'($urandom % 2));
    q.push_back(kinds[$] ? 8'h5b : 8'h7b);
    while (kinds.size() > 0) begin
      steps++;
      if (mode == 1 || (mode == 0 && ($urandom % 4 == 0 || steps > 30))) begin
        emit_ws();
        if (mode == 1 && steps <= 30 && ($urandom % 2) == 1) begin
          q.push_back(8'h2c); emit_ws(); mode = 2;
        end else begin
          q.push_back(kinds[$] ? 8'h5d : 8'h7d);
          void'(kinds.pop_back());
          mode = 1;
        end
      end else begin
        emit_ws();
        if (!kinds[$]) begin emit_str(); emit_ws(); q.push_back(8'h3a); emit_ws(); end
        if (($urandom % 3 == 0 || kinds.size() < 2) && kinds.size() < maxd && steps <= 30) begin
          kinds.push_back(1'($urandom % 2));
          q.push_back(kinds[$] ? 8'h5b : 8'h7b);
          mode = 0;
        end else begin
          if ($urandom % 2) emit_str(); else emit_num();
          mode = 1;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic e, dn; logic [2:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    check(err_flag == 1'b0, "R10", "no error after reset", int'(err_flag), 0);
    check(err_code == 3'd0, "R10", "code after reset", int'(err_code), 0);
    check(doc_done == 1'b0, "R11", "done after reset", int'(doc_done), 0);

    // directed cases: error index, code, done count, last done index
    run_str("{,", "R3", 1, 1, 0, -1);
    run_str("x", "R2", 0, 1, 0, -1);
    run_str("  \n[ ]", "R2", -1, 0, 1, 5);
    run_str("[}", "R7", 1, 2, 0, -1);
    run_str("{]", "R7", 1, 2, 0, -1);
    run_str("}", "R9", 0, 4, 0, -1);
    run_str("[[[[[", "R8", 4, 3, 0, -1);
    run_str("[[{\"a\":[]}]]", "R8", -1, 0, 1, 11);
    run_str("{\"a{]\":\"x,\\\"}\"}", "R4", -1, 0, 1, 14);
    run_str("[12,-3.5e2]", "R5", -1, 0, 1, 10);
    run_str("[1 2]", "R5", 3, 1, 0, -1);
    run_str("{\"a\" 1}", "R6", 5, 1, 0, -1);
    run_str("{\"k\":[1,{}],\"z\":\"v\"}", "R6", -1, 0, 1, 19);
    run_str("{\"a\":1,}", "R6", 7, 1, 0, -1);
    run_str("{}[]", "R11", -1, 0, 2, 3);
    run_str("[}][]", "R10", 1, 2, 0, -1);

    // R1: bytes with in_valid low are not consumed
    do_sof();
    @(negedge clk); in_valid = 1'b0; in_data = 8'h7d;
    #1; check(err_flag == 1'b0, "R1", "invalid byte ignored", int'(err_flag), 0);
    @(negedge clk); #1;
    check(err_flag == 1'b0, "R1", "still clean", int'(err_flag), 0);
    q.delete(); q.push_back(8'h5b); q.push_back(8'h5d);
    run_q("R1", -1, 0, 1, 1);

    // R12: sof clears an error; byte in the sof cycle ignored
    run_str("]", "R12", 0, 4, 0, -1);
    @(negedge clk); sof = 1'b1; in_valid = 1'b1; in_data = 8'h7d;
    #1; check(doc_done == 1'b0, "R12", "no done in sof cycle", int'(doc_done), 0);
    @(negedge clk); sof = 1'b0; in_valid = 1'b0;
    #1; check(err_flag == 1'b0, "R12", "error cleared by sof", int'(err_flag), 0);
    q.delete(); q.push_back(8'h7b); q.push_back(8'h7d);
    run_q("R12", -1, 0, 1, 1);

    // R10: reset also clears an error
    run_str("{,", "R10", 1, 1, 0, -1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    check(err_flag == 1'b0, "R10", "error cleared by reset", int'(err_flag), 0);
    feed(8'h5b, e, c, dn);
    feed(8'h5d, e, c, dn);
    check(dn == 1'b1, "R11", "done after reset", int'(dn), 1);
    idle();

    // random well-formed documents, single and back to back
    for (int k = 0; k < 40; k++) begin
      q.delete();
      gen_doc(DEPTH);
      do_sof();
      run_q("R4", -1, 0, 1, q.size() - 1);
    end
    for (int k = 0; k < 10; k++) begin
      q.delete();
      gen_doc(DEPTH);
      gen_doc(DEPTH);
      do_sof();
      run_q("R11", -1, 0, 2, q.size() - 1);
    end
    // random document corrupted by one extra opening level beyond the limit
    q.delete();
    for (int i = 0; i <= DEPTH; i++) q.push_back(($urandom % 2) ? 8'h5b : 8'h7b);
    for (int i = 0; i < DEPTH; i++)
      if (q[i] == 8'h7b) q[i] = 8'h5b;
    do_sof();
    run_q("R8", DEPTH, 3, 0, -1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule